// File: doc/BRIEF.md
# Branch Trace Address Queue

This block keeps a short history of control-flow transfers so that a debugger can see how the processor reached its current point. Every taken branch, interrupt or exception reported on the event inputs becomes one record that holds a source address and a destination address. A branch records the address of the branch instruction and its target. An interrupt or exception records the saved return PC and the entry address of the handler. Transfers from the end of a hardware repeat loop back to its start are not recorded.

Records are kept only while the trace enable bit in the control register is 1. New records go in at the head and older ones move back, so the newest record is read first. Once all eight slots hold a record, the next one pushes the oldest out. Software reads a record through two register offsets, source first and then destination. Both offsets show the head record. Reading the destination offset removes the head record, and the next one moves up. Turning the enable bit off and then on again discards every record.

Top module: `brtrace_queue`

## Requirements
- R1: After reset the enable bit reads 0, the queue is empty, and a read of the source or destination offset returns 0.
- R2: An event that arrives while the enable bit is 0 creates no record.
- R3: A branch event (`evt_kind` = 0) stores `evt_branch_pc` as the source and `evt_target_pc` as the destination.
- R4: An interrupt or exception event (`evt_kind` = 1) stores `evt_epc` as the source and `evt_vector_pc` as the destination.
- R5: The queue holds eight records and returns the newest first. A ninth record discards the oldest one.
- R6: Reading the source offset (offset 1) leaves the queue unchanged. Reading the destination offset (offset 2) removes the head record.
- R7: A read of an empty queue returns 0 and moves nothing, so later records are still read correctly.
- R8: An event with `evt_hwloop` = 1 creates no record.
- R9: Writing 0 to the enable bit keeps the records readable. A later write of 1 to a cleared enable bit discards all records.
- R10: When an event and a destination read fall in the same cycle, the read returns the head record as it was before the cycle. The new event becomes the head, and the other records stay in place.
- R11: Offset 0 is the control register, and bit 0 is the enable bit, which reads back as written. Read data appears on `reg_rdata` one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | A control transfer happened this cycle |
| evt_kind | input | 1 | 0 = branch instruction, 1 = interrupt or exception |
| evt_hwloop | input | 1 | The transfer is a hardware repeat-loop wrap |
| evt_branch_pc | input | 32 | Address of the branch instruction |
| evt_target_pc | input | 32 | Branch target address |
| evt_epc | input | 32 | Return PC saved for the exception |
| evt_vector_pc | input | 32 | Start address of the handler |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 source, 2 destination |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |

## Verification
The bench fills the queue past its depth and reads every pair back. A design that drops the wrong end of the queue, or shifts on the wrong read, returns records out of order or returns repeated records. It reads the source offset twice and reads an empty queue. If the pointer moved on either read, a later record would be lost or a stale one would come back. It places a destination read in the same cycle as a new event. Applying the shift and the insert in the wrong order would either lose the new record or return post-shift data. It also checks that the enable toggle discards records, that a plain disable keeps them, that loop wraps are not recorded, and that an exception stores the return PC and handler address rather than the branch fields.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_SRC  = 2'd1,
        RA_DST  = 2'd2
    } reg_ofs_e;

    typedef enum logic {
        EVK_BRANCH = 1'b0,
        EVK_EXCEPT = 1'b1
    } evt_kind_e;
endpackage

// File: rtl/brtrace_select.sv
module brtrace_select #(
    parameter int unsigned AW = 32
) (
    input  logic          evt_valid,
    input  logic          evt_kind,
    input  logic          evt_hwloop,
    input  logic          trace_en,
    input  logic [AW-1:0] branch_pc,
    input  logic [AW-1:0] target_pc,
    input  logic [AW-1:0] epc,
    input  logic [AW-1:0] vector_pc,
    output logic          push,
    output logic [AW-1:0] push_src,
    output logic [AW-1:0] push_dst
);
    import brtrace_pkg::*;

    always_comb begin
        push = evt_valid && trace_en && !evt_hwloop;
        if (evt_kind == EVK_EXCEPT) begin
            push_src = epc;
            push_dst = vector_pc;
        end else begin
            push_src = branch_pc;
            push_dst = target_pc;
        end
    end
endmodule

// File: rtl/brtrace_fifo.sv
module brtrace_fifo #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [AW-1:0]    push_src,
    input  logic [AW-1:0]    push_dst,
    input  logic             pop,
    output logic             head_vld,
    output logic [AW-1:0]    head_src,
    output logic [AW-1:0]    head_dst,
    output logic [DEPTH-1:0] vld_o
);
    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][AW-1:0] src;
        logic [DEPTH-1:0][AW-1:0] dst;
    } qstate_t;

    qstate_t st_q, st_d, popped;
    logic    pop_eff;

    assign pop_eff = pop && st_q.vld[0];

    always_comb begin
        popped = st_q;
        if (pop_eff) begin
            popped.vld = st_q.vld >> 1;
            for (int i = 0; i < LAST; i++) begin
                popped.src[i] = st_q.src[i+1];
                popped.dst[i] = st_q.dst[i+1];
            end
        end
        st_d = popped;
        if (push) begin
            for (int i = 1; i < DEPTH; i++) begin
                st_d.vld[i] = popped.vld[i-1];
                st_d.src[i] = popped.src[i-1];
                st_d.dst[i] = popped.dst[i-1];
            end
            st_d.vld[0] = 1'b1;
            st_d.src[0] = push_src;
            st_d.dst[0] = push_dst;
        end
        if (clr) begin
            st_d.vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_vld = st_q.vld[0];
    assign head_src = st_q.src[0];
    assign head_dst = st_q.dst[0];
    assign vld_o    = st_q.vld;

    // R5
    thermo_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.vld + 1'b1) & st_q.vld) == '0);

    // R5
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_eff && !clr && !st_q.vld[LAST])
        |=> ($countones(st_q.vld) == $countones($past(st_q.vld)) + 1));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !st_q.vld[0] && !push && !clr) |=> $stable(st_q.vld));

    // R6
    pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_eff && !push && !clr)
        |=> ($countones(st_q.vld) + 1 == $countones($past(st_q.vld))));
endmodule

// File: rtl/brtrace_queue.sv
module brtrace_queue #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic          evt_kind,
    input  logic          evt_hwloop,
    input  logic [AW-1:0] evt_branch_pc,
    input  logic [AW-1:0] evt_target_pc,
    input  logic [AW-1:0] evt_epc,
    input  logic [AW-1:0] evt_vector_pc,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata
);
    import brtrace_pkg::*;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] rdata;
    } ctl_t;

    ctl_t             ctl_q, ctl_d;
    logic             wr_ctrl, clr, pop_req;
    logic             push;
    logic [AW-1:0]    push_src, push_dst;
    logic             head_vld;
    logic [AW-1:0]    head_src, head_dst;
    logic [DEPTH-1:0] vld;

    brtrace_select #(.AW(AW)) u_select (
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_hwloop(evt_hwloop),
        .trace_en  (ctl_q.en),
        .branch_pc (evt_branch_pc),
        .target_pc (evt_target_pc),
        .epc       (evt_epc),
        .vector_pc (evt_vector_pc),
        .push      (push),
        .push_src  (push_src),
        .push_dst  (push_dst)
    );

    brtrace_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .push    (push),
        .push_src(push_src),
        .push_dst(push_dst),
        .pop     (pop_req),
        .head_vld(head_vld),
        .head_src(head_src),
        .head_dst(head_dst),
        .vld_o   (vld)
    );

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
        clr     = wr_ctrl && reg_wdata[0] && !ctl_q.en;
        pop_req = reg_rd && (reg_addr == RA_DST);
        ctl_d   = ctl_q;
        if (wr_ctrl) ctl_d.en = reg_wdata[0];
        if (reg_rd) begin
            case (reg_addr)
                RA_CTRL: ctl_d.rdata = {{(AW-1){1'b0}}, ctl_q.en};
                RA_SRC:  ctl_d.rdata = head_vld ? head_src : '0;
                RA_DST:  ctl_d.rdata = head_vld ? head_dst : '0;
                default: ctl_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign reg_rdata = ctl_q.rdata;

    // R9
    reenable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld == '0));

    // R2
    disabled_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.en && !pop_req && !wr_ctrl) |=> $stable(vld));

    // R8
    hwloop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_hwloop && !pop_req && !wr_ctrl)
        |=> ($stable(vld) && $stable(head_src) && $stable(head_dst)));

    // R4
    exc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind && !evt_hwloop && ctl_q.en && !wr_ctrl)
        |=> (head_vld && head_src == $past(evt_epc) && head_dst == $past(evt_vector_pc)));

    // R11
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_CTRL) |=> (reg_rdata == AW'($past(ctl_q.en))));
endmodule

// File: tb/brtrace_queue_bench.sv
module brtrace_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 0, evt_kind = 0, evt_hwloop = 0;
    logic [31:0] evt_branch_pc = 0, evt_target_pc = 0, evt_epc = 0, evt_vector_pc = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    brtrace_queue u_brtrace_queue (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_hwloop(evt_hwloop),
        .evt_branch_pc(evt_branch_pc), .evt_target_pc(evt_target_pc),
        .evt_epc(evt_epc), .evt_vector_pc(evt_vector_pc),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic v);
        @(negedge clk);
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = {31'd0, v};
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        v = reg_rdata;
    endtask

    task automatic set_ev(input logic k, input logic hw, input logic [31:0] b,
                          input logic [31:0] t, input logic [31:0] e, input logic [31:0] vec);
        evt_valid = 1; evt_kind = k; evt_hwloop = hw;
        evt_branch_pc = b; evt_target_pc = t; evt_epc = e; evt_vector_pc = vec;
    endtask

    task automatic ev(input logic k, input logic hw, input logic [31:0] b,
                      input logic [31:0] t, input logic [31:0] e, input logic [31:0] vec);
        @(negedge clk);
        set_ev(k, hw, b, t, e, vec);
        @(negedge clk);
        evt_valid = 0; evt_hwloop = 0;
    endtask

    task automatic fresh();
        wr_ctrl(1'b0);
        wr_ctrl(1'b1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R1 ctrl after reset", v, 32'd0);
        rd(2'd1, v); chk("R1 src after reset", v, 32'd0);
        rd(2'd2, v); chk("R1 dst after reset", v, 32'd0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        ev(1'b0, 1'b0, 32'hAAAA_0000, 32'hBBBB_0000, 32'h0, 32'h0);
        wr_ctrl(1'b1);
        rd(2'd0, v); chk("R11 ctrl readback", v, 32'd1);
        rd(2'd1, v); chk("R2 no capture while disabled", v, 32'd0);
    endtask

    task automatic t_branch();
        logic [31:0] v;
        fresh();
        ev(1'b0, 1'b0, 32'h0000_1000, 32'h0000_2000, 32'hDEAD_0001, 32'hDEAD_0002);
        rd(2'd1, v); chk("R3 branch src", v, 32'h0000_1000);
        rd(2'd1, v); chk("R6 src reread unchanged", v, 32'h0000_1000);
        rd(2'd2, v); chk("R3 branch dst", v, 32'h0000_2000);
        rd(2'd1, v); chk("R6 dst read advanced", v, 32'd0);
    endtask

    task automatic t_exc();
        logic [31:0] v;
        fresh();
        ev(1'b1, 1'b0, 32'h1111_1111, 32'h2222_2222, 32'h0000_3004, 32'h8000_0400);
        rd(2'd1, v); chk("R4 exception src", v, 32'h0000_3004);
        rd(2'd2, v); chk("R4 exception dst", v, 32'h8000_0400);
    endtask

    task automatic t_depth();
        logic [31:0] v;
        fresh();
        for (int k = 1; k <= 9; k++)
            ev(1'b0, 1'b0, 32'h100 * k, 32'h10000 + k, 32'h0, 32'h0);
        for (int k = 9; k >= 2; k--) begin
            rd(2'd1, v); chk("R5 newest-first src", v, 32'h100 * k);
            rd(2'd2, v); chk("R5 newest-first dst", v, 32'h10000 + k);
        end
        rd(2'd1, v); chk("R5 oldest dropped", v, 32'd0);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        fresh();
        rd(2'd2, v); chk("R7 empty dst read", v, 32'd0);
        ev(1'b0, 1'b0, 32'h0000_5550, 32'h0000_6660, 32'h0, 32'h0);
        rd(2'd1, v); chk("R7 src after empty read", v, 32'h0000_5550);
        rd(2'd2, v); chk("R7 dst after empty read", v, 32'h0000_6660);
    endtask

    task automatic t_hwloop();
        logic [31:0] v;
        fresh();
        ev(1'b0, 1'b1, 32'h0000_7000, 32'h0000_6F00, 32'h0, 32'h0);
        rd(2'd1, v); chk("R8 loop wrap not recorded", v, 32'd0);
        ev(1'b0, 1'b0, 32'h0000_7100, 32'h0000_7200, 32'h0, 32'h0);
        ev(1'b1, 1'b1, 32'h0, 32'h0, 32'h0000_7300, 32'h0000_7400);
        rd(2'd1, v); chk("R8 head kept after wrap", v, 32'h0000_7100);
    endtask

    task automatic t_toggle();
        logic [31:0] v;
        fresh();
        ev(1'b0, 1'b0, 32'h0000_9000, 32'h0000_9100, 32'h0, 32'h0);
        wr_ctrl(1'b0);
        rd(2'd0, v); chk("R11 ctrl reads 0", v, 32'd0);
        rd(2'd1, v); chk("R9 kept while disabled", v, 32'h0000_9000);
        wr_ctrl(1'b1);
        rd(2'd1, v); chk("R9 cleared on re-enable", v, 32'd0);
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        fresh();
        ev(1'b0, 1'b0, 32'h0000_A000, 32'h0000_A100, 32'h0, 32'h0);
        ev(1'b0, 1'b0, 32'h0000_B000, 32'h0000_B100, 32'h0, 32'h0);
        @(negedge clk);
        set_ev(1'b0, 1'b0, 32'h0000_C000, 32'h0000_C100, 32'h0, 32'h0);
        reg_rd = 1; reg_addr = 2'd2;
        @(negedge clk);
        evt_valid = 0; reg_rd = 0;
        v = reg_rdata; chk("R10 pre-shift dst", v, 32'h0000_B100);
        rd(2'd1, v); chk("R10 new event at head", v, 32'h0000_C000);
        rd(2'd2, v); chk("R10 new event dst", v, 32'h0000_C100);
        rd(2'd1, v); chk("R10 older kept src", v, 32'h0000_A000);
        rd(2'd2, v); chk("R10 older kept dst", v, 32'h0000_A100);
        rd(2'd1, v); chk("R10 nothing extra", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_disabled();
        t_branch();
        t_exc();
        t_depth();
        t_empty();
        t_hwloop();
        t_toggle();
        t_overlap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule